// File: doc/BRIEF.md
# Cascaded Programmable Clock-Enable Divider Pair

This block produces two slow clock-enable streams inside one system clock domain. A first stage counts ticks of a root source and emits a single-cycle enable once every (code+1) ticks. A second stage counts only the first stage's enables and divides them again by its own (code+1). The root source is either the system clock itself, giving one tick per cycle, or an asynchronous external clock. The external clock is brought into the domain through a synchronizer, and each rising edge becomes one tick.

Both 4-bit divide codes sit in one 8-bit configuration register. A separate select input picks the root source. A small source-control state machine has three states: SRC_INT (internal ticks), SRC_EXT (synchronized external ticks) and SRC_FLUSH (a one-cycle quiet state in which both counters reload). It moves SRC_INT→SRC_FLUSH when the select goes high and SRC_EXT→SRC_FLUSH when the select goes low. From SRC_FLUSH it moves to SRC_EXT or SRC_INT according to the select. Each enable output also has a companion output that toggles on every enable pulse. This gives a square wave at half the enable rate.

Top module: `vclk_cascade`

## Requirements
- R1: A synchronous active-high reset clears the configuration register, both counters and both toggle outputs to 0. In internal mode after reset, `en_a` and `en_b` are high on every cycle (divide by 1).
- R2: A write with `cfg_we` high loads `cfg_wdata` at the next rising edge. Bits 7:4 are the first-stage code and bits 3:0 are the second-stage code.
- R3: `en_a` is a single-cycle pulse that occurs once every (first code + 1) root ticks, for every code 0..15.
- R4: `en_b` occurs once every (second code + 1) `en_a` pulses, which is (first+1)*(second+1) root ticks, and only in a cycle where `en_a` is also high.
- R5: In internal mode the root source ticks on every system clock cycle.
- R6: In external mode, each rising edge of `ext_clk_in` gives exactly one root tick. With first code 0, `en_a` rises in the third cycle after the cycle in which the input goes high.
- R7: A code change does not cut short the count already in progress. The new code applies from that stage's next reload, so the period running at the write keeps its old length.
- R8: Any change of `src_ext` causes one SRC_FLUSH cycle with no enables. Both counters reload their codes in that cycle, so the first period from the new source is full length.
- R9: `tog_a` / `tog_b` invert in the cycle after each `en_a` / `en_b` pulse and hold their value otherwise.
- R10: In external mode with `ext_clk_in` held static, neither enable pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration data: [7:4] first code, [3:0] second code |
| src_ext | input | 1 | Root source select: 0 internal, 1 external |
| ext_clk_in | input | 1 | Asynchronous external clock |
| en_a | output | 1 | First-stage enable pulse |
| en_b | output | 1 | Second-stage enable pulse |
| tog_a | output | 1 | Toggle view of `en_a` |
| tog_b | output | 1 | Toggle view of `en_b` |

## Verification
The hardest case to reach is a source switch while the first counter is partway through a count. A long internal count does not help, because the count is already finished by the time the switch lands. The stimulus therefore switches to external mode and sends exactly three external edges so the counter stops at a known midpoint. It then holds the external input low and switches back to internal mode. The bench counts the cycles to the first `en_a` and expects a full period plus the flush cycle. A stale counter would pulse early. The divide ratios are swept over all 256 code pairs, with the periods computed arithmetically.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
    localparam int CODE_W      = 4;
    localparam int NUM_STAGES  = 2;
    localparam int CFG_W       = CODE_W * NUM_STAGES;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic [1:0] {
        SRC_INT   = 2'd0,
        SRC_EXT   = 2'd1,
        SRC_FLUSH = 2'd2
    } src_state_t;
endpackage

// File: rtl/vclk_edge_sync.sv
module vclk_edge_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] sr_q;
    logic             prev_q;
    logic             rise_q;

    always_ff @(posedge clk) begin
        if (rst) sr_q[0] <= 1'b0;
        else     sr_q[0] <= din;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) sr_q[i] <= 1'b0;
            else     sr_q[i] <= sr_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            prev_q <= sr_q[LAST];
            rise_q <= sr_q[LAST] & ~prev_q;
        end
    end

    assign rise = rise_q;
endmodule

// File: rtl/vclk_divstage.sv
module vclk_divstage #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              pulse
);
    logic [CODE_W-1:0] cnt_q;
    logic              at_end;

    assign at_end = (cnt_q == '0);
    assign pulse  = tick & at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= code;
        end else if (tick) begin
            if (at_end) cnt_q <= code;
            else        cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/vclk_cascade.sv
module vclk_cascade
    import vclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             src_ext,
    input  logic             ext_clk_in,
    output logic             en_a,
    output logic             en_b,
    output logic             tog_a,
    output logic             tog_b
);
    src_state_t         state_q, state_d;
    logic [CFG_W-1:0]   cfg_q;
    logic               ext_tick;
    logic               src_tick;
    logic               flush;
    logic [NUM_STAGES:0]   tick_vec;
    logic [NUM_STAGES-1:0] tog_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    vclk_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_clk_in),
        .rise (ext_tick)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_INT:   if (src_ext)  state_d = SRC_FLUSH;
            SRC_EXT:   if (!src_ext) state_d = SRC_FLUSH;
            SRC_FLUSH: state_d = src_ext ? SRC_EXT : SRC_INT;
            default:   state_d = SRC_INT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SRC_INT;
        else     state_q <= state_d;
    end

    always_comb begin
        src_tick = 1'b0;
        flush    = 1'b0;
        unique case (state_q)
            SRC_INT:   src_tick = 1'b1;
            SRC_EXT:   src_tick = ext_tick;
            SRC_FLUSH: flush    = 1'b1;
            default:   flush    = 1'b1;
        endcase
    end

    assign tick_vec[0] = src_tick;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        localparam int LSB = (NUM_STAGES - 1 - s) * CODE_W;

        vclk_divstage #(.CODE_W(CODE_W)) u_div (
            .clk   (clk),
            .rst   (rst),
            .clr   (flush),
            .tick  (tick_vec[s]),
            .code  (cfg_q[LSB +: CODE_W]),
            .pulse (tick_vec[s+1])
        );

        always_ff @(posedge clk) begin
            if (rst)                tog_q[s] <= 1'b0;
            else if (tick_vec[s+1]) tog_q[s] <= ~tog_q[s];
        end
    end

    assign en_a  = tick_vec[1];
    assign en_b  = tick_vec[2];
    assign tog_a = tog_q[0];
    assign tog_b = tog_q[1];
endmodule

// File: rtl/vclk_cascade_chk.sv
module vclk_cascade_chk (
    input logic clk,
    input logic rst,
    input logic src_ext,
    input logic src_tick,
    input logic en_a,
    input logic en_b,
    input logic tog_a,
    input logic tog_b
);
    AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (rst)
        en_b |-> en_a); // R4

    AST_A_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        en_a |-> src_tick); // R3

    AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (src_ext != $past(src_ext)) |=> (!en_a && !en_b)); // R8

    AST_TOG_A_FLIP: assert property (@(posedge clk) disable iff (rst)
        en_a |=> (tog_a != $past(tog_a))); // R9

    AST_TOG_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_a |=> $stable(tog_a)); // R9

    AST_TOG_B_FLIP: assert property (@(posedge clk) disable iff (rst)
        en_b |=> (tog_b != $past(tog_b))); // R9
endmodule

bind vclk_cascade vclk_cascade_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .src_ext  (src_ext),
    .src_tick (src_tick),
    .en_a     (en_a),
    .en_b     (en_b),
    .tog_a    (tog_a),
    .tog_b    (tog_b)
);

// File: tb/vclk_cascade_tb_top.sv
`timescale 1ns/1ps
module vclk_cascade_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       src_ext = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic       en_a, en_b, tog_a, tog_b;

    int total = 0;
    int bad = 0;
    int tog_chk = 0;
    int tog_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vclk_cascade dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .src_ext    (src_ext),
        .ext_clk_in (ext_clk_in),
        .en_a       (en_a),
        .en_b       (en_b),
        .tog_a      (tog_a),
        .tog_b      (tog_b)
    );

    // R9: toggle outputs follow previous-cycle enables
    logic pa_en = 1'b0, pb_en = 1'b0, pa_tg = 1'b0, pb_tg = 1'b0;
    bit   have_prev = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
        end else begin
            if (have_prev) begin
                tog_chk <= tog_chk + 1;
                if (tog_a != (pa_tg ^ pa_en) || tog_b != (pb_tg ^ pb_en))
                    tog_err <= tog_err + 1;
            end
            have_prev <= 1'b1;
            pa_en <= en_a; pb_en <= en_b; pa_tg <= tog_a; pb_tg <= tog_b;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wdata = v;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic measure(output int pa, output int pb);
        int k = 0, la = -1, lb = -1, nb = 0;
        pa = -1; pb = -1;
        while (nb < 3 && k < 3000) begin
            @(negedge clk);
            k++;
            if (en_a) begin
                if (la >= 0) pa = k - la;
                la = k;
            end
            if (en_b) begin
                if (lb >= 0) pb = k - lb;
                lb = k;
                nb++;
            end
        end
    endtask

    task automatic ext_pulses(input int n);
        repeat (n) begin
            ext_clk_in = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int pa, pb, first_k, cnt;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(tog_a == 1'b0 && tog_b == 1'b0, "R1 toggles cleared", {tog_a, tog_b}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(en_a == 1'b1, "R1 en_a divide-by-1 after reset", en_a, 1);
        check(en_b == 1'b1, "R1 en_b divide-by-1 after reset", en_b, 1);
        measure(pa, pb);
        check(pa == 1, "R5 internal tick each cycle", pa, 1);

        // R2: field placement, first code in upper nibble
        write_cfg(8'h31);
        measure(pa, pb);
        check(pa == 4, "R2 upper nibble drives first stage", pa, 4);
        check(pb == 8, "R2 lower nibble drives second stage", pb, 8);

        // R3 / R4: exhaustive sweep in internal mode
        for (int ca = 0; ca < 16; ca++) begin
            for (int cb = 0; cb < 16; cb++) begin
                write_cfg({ca[3:0], cb[3:0]});
                measure(pa, pb);
                check(pa == ca + 1, "R3 first-stage period", pa, ca + 1);
                check(pb == (ca + 1) * (cb + 1), "R4 cascaded period", pb, (ca + 1) * (cb + 1));
            end
        end

        // R7: code change mid-count keeps current period
        write_cfg(8'hF0);
        @(negedge clk);
        while (!en_a) @(negedge clk);
        repeat (3) @(negedge clk);
        cfg_wdata = 8'h20; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        cnt = 4;
        while (!en_a && cnt < 100) begin @(negedge clk); cnt++; end
        check(cnt == 16, "R7 running period unchanged", cnt, 16);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!en_a && cnt < 100);
        check(cnt == 3, "R7 new code after reload", cnt, 3);

        // R6: external edge latency with first code 0
        write_cfg(8'h00);
        src_ext = 1'b1;
        repeat (4) @(negedge clk);
        // R10: static external input gives no enables
        cnt = 0;
        repeat (100) begin @(negedge clk); if (en_a || en_b) cnt++; end
        check(cnt == 0, "R10 static external no enables", cnt, 0);
        ext_clk_in = 1'b1;
        first_k = -1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (en_a && first_k < 0) first_k = k;
        end
        check(first_k == 3, "R6 external edge latency", first_k, 3);
        ext_clk_in = 1'b0;
        repeat (4) @(negedge clk);

        // R6: external ratio, square wave of period 6 cycles
        write_cfg(8'h21);
        fork
            ext_pulses(40);
            measure(pa, pb);
        join
        check(pa == 18, "R6 external first-stage period", pa, 18);
        check(pb == 36, "R6 external cascaded period", pb, 36);
        repeat (4) @(negedge clk);

        // R8: switch while first counter is mid-count
        write_cfg(8'h90);
        src_ext = 1'b0;
        repeat (4) @(negedge clk);
        src_ext = 1'b1;
        repeat (4) @(negedge clk);
        ext_pulses(3);
        repeat (6) @(negedge clk);
        src_ext = 1'b0;
        first_k = -1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (en_a && first_k < 0) first_k = k;
        end
        check(first_k == 11, "R8 full period after source switch", first_k, 11);

        check(tog_err == 0 && tog_chk > 1000, "R9 toggle outputs", tog_err, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule